// File: doc/BRIEF.md
# Configurable External Bus Strobe Generator

This block turns internal read and write requests into the control strobes of a 16-bit multiplexed address/data bus. Each request carries an address and two byte enables. A run of fixed length follows each accepted request: one address clock, a programmable number of strobe clocks, and one recovery clock. The recovery clock carries a one-clock done pulse. During the address clock the request address is presented on the address output so that external logic can capture it.

Two configuration inputs give the pins four personalities at run time. The address-style bit picks one of two behaviours for the address pin. In one it is a high-going latch pulse. In the other it is a low-going address-valid strobe. The write-style bit picks one of two pairs of pins. One pair is a single write strobe plus a high-byte enable. The other is two per-lane write strobes. A single cycle sequencer serves all four personalities. The configuration is captured when a request is accepted, so a change made in the middle of a cycle only affects the next cycle.

Top module: `bus_strobe_gen`

## Requirements
- R1: Every accepted request produces one address clock, then STROBE_CLKS strobe clocks, then one recovery clock. `done_o` is high in the recovery clock and in no other clock.
- R2: With `cfg_addr_style` = 1 (latch pulse) captured, `addr_pin_o` is high in the address clock only. It is low in the strobe clocks, the recovery clock and while idle.
- R3: With `cfg_addr_style` = 0 (address valid) captured, `addr_pin_o` is low in the address clock and in the strobe clocks. It is high in the recovery clock and while idle, which gives at least one high clock between cycles.
- R4: `rd_n_o` is low in the strobe clocks of a read cycle (`req_write` = 0) and high at all other times.
- R5: With `cfg_wr_style` = 1 captured, `wr_pin_o` is low in the strobe clocks of every write cycle. With `cfg_wr_style` = 0, it is low in the strobe clocks of a write only when `req_be[0]` (low byte, active high) is set. It is high at all other times, including the whole of every read.
- R6: With `cfg_wr_style` = 1 captured, `hb_pin_o` is a high-byte enable. It is low in the address and strobe clocks of any cycle, read or write, whose `req_be[1]` (high byte, active high) is set. With `cfg_wr_style` = 0 it is the high-lane write strobe: low in the strobe clocks of a write with `req_be[1]` set. It is high otherwise.
- R7: `ad_o` carries the captured request address in the address clock and is zero in every other clock.
- R8: A request is accepted only on a clock edge while the block is idle or in a recovery clock. The following clock is the address clock. A request held during the address or strobe clocks is ignored.
- R9: Both configuration bits, the direction, the byte enables and the address are captured at acceptance. Changing them during a cycle does not alter that cycle's outputs.
- R10: While reset is asserted and after reset with no request, the block is idle in the latch-pulse, single-write-strobe personality. `addr_pin_o` is low, `rd_n_o`, `wr_pin_o` and `hb_pin_o` are high, `done_o` is low and `ad_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr_style | input | 1 | 1: address latch pulse, 0: address-valid strobe |
| cfg_wr_style | input | 1 | 1: write strobe plus high-byte enable, 0: split lane write strobes |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | ADDR_W | Request address |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte, active high |
| addr_pin_o | output | 1 | Latch pulse (high active) or address valid (low active) |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_pin_o | output | 1 | Write strobe or low-lane write strobe, active low |
| hb_pin_o | output | 1 | High-byte enable or high-lane write strobe, active low |
| done_o | output | 1 | One-clock done pulse in the recovery clock |
| ad_o | output | ADDR_W | Address presented during the address clock |

## Verification
The bench builds the block with its defaults: STROBE_CLKS = 2, which gives the four-clock cycle, and ADDR_W = 16. This brings every phase boundary of the standard cycle within reach. Random requests arrive in idle, recovery and busy clocks, and the configuration bits toggle at random, so all four personalities, back-to-back cycles, ignored requests and mid-cycle configuration changes occur many times. A behavioural model, driven only by the requirements, follows each clock as an integer position within the cycle.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_RECV = 2'd3
  } phase_t;

  typedef struct packed {
    logic addr_style;  // 1: latch pulse, 0: address-valid strobe
    logic wr_style;    // 1: write + high-byte enable, 0: split lane strobes
  } cfg_t;

  localparam cfg_t CFG_RESET = '{addr_style: 1'b1, wr_style: 1'b1};
  localparam int   LANES     = 2;

  // Level of the address pin for a given personality and phase.
  function automatic logic addr_pin_level(input cfg_t cfg, input phase_t ph);
    logic in_cycle;
    in_cycle = (ph == PH_ADDR) || (ph == PH_STRB);
    if (cfg.addr_style) return (ph == PH_ADDR);
    return !in_cycle;
  endfunction

  // Active-low level of a lane write strobe.
  function automatic logic lane_wr_level(input phase_t ph, input logic wr, input logic be);
    return !((ph == PH_STRB) && wr && be);
  endfunction

endpackage

// File: rtl/bsg_seq.sv
module bsg_seq
  import bsg_pkg::*;
#(
  parameter int STROBE_CLKS = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  output phase_t phase,
  output logic   start
);

  localparam int CNT_W = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CLKS - 1);

  logic [CNT_W-1:0] cnt;

  assign start = req_valid && ((phase == PH_IDLE) || (phase == PH_RECV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_ADDR;
        PH_ADDR: begin
          phase <= PH_STRB;
          cnt   <= '0;
        end
        PH_STRB: begin
          if (cnt == CNT_LAST) phase <= PH_RECV;
          else                 cnt   <= cnt + 1'b1;
        end
        PH_RECV: phase <= start ? PH_ADDR : PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bsg_capture.sv
module bsg_capture
  import bsg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cfg_t              cfg_in,
  input  logic              wr_in,
  input  logic [LANES-1:0]  be_in,
  input  logic [ADDR_W-1:0] addr_in,
  output cfg_t              cfg_q,
  output logic              wr_q,
  output logic [LANES-1:0]  be_q,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      wr_q   <= 1'b0;
      be_q   <= '0;
      addr_q <= '0;
    end else if (start) begin
      cfg_q  <= cfg_in;
      wr_q   <= wr_in;
      be_q   <= be_in;
      addr_q <= addr_in;
    end
  end

endmodule

// File: rtl/bsg_pins.sv
module bsg_pins
  import bsg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  phase_t            phase,
  input  cfg_t              cfg_q,
  input  logic              wr_q,
  input  logic [LANES-1:0]  be_q,
  input  logic [ADDR_W-1:0] addr_q,
  output logic              addr_pin_o,
  output logic              rd_n_o,
  output logic              wr_pin_o,
  output logic              hb_pin_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] ad_o
);

  logic [LANES-1:0] lane_wr_n;
  logic             in_strobe;
  logic             in_cycle;

  assign in_strobe = (phase == PH_STRB);
  assign in_cycle  = (phase == PH_ADDR) || in_strobe;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr_n[g] = lane_wr_level(phase, wr_q, be_q[g]);
  end

  assign addr_pin_o = addr_pin_level(cfg_q, phase);
  assign rd_n_o     = !(in_strobe && !wr_q);
  assign wr_pin_o   = cfg_q.wr_style ? !(in_strobe && wr_q) : lane_wr_n[0];
  assign hb_pin_o   = cfg_q.wr_style ? !(in_cycle && be_q[1]) : lane_wr_n[1];
  assign done_o     = (phase == PH_RECV);
  assign ad_o       = (phase == PH_ADDR) ? addr_q : '0;

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bsg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int STROBE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_addr_style,
  input  logic              cfg_wr_style,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  output logic              addr_pin_o,
  output logic              rd_n_o,
  output logic              wr_pin_o,
  output logic              hb_pin_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] ad_o
);

  phase_t            phase;
  logic              start;
  cfg_t              cfg_in;
  cfg_t              cfg_q;
  logic              wr_q;
  logic [LANES-1:0]  be_q;
  logic [ADDR_W-1:0] addr_q;

  assign cfg_in = '{addr_style: cfg_addr_style, wr_style: cfg_wr_style};

  bsg_seq #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .phase     (phase),
    .start     (start)
  );

  bsg_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cfg_in  (cfg_in),
    .wr_in   (req_write),
    .be_in   (req_be),
    .addr_in (req_addr),
    .cfg_q   (cfg_q),
    .wr_q    (wr_q),
    .be_q    (be_q),
    .addr_q  (addr_q)
  );

  bsg_pins #(.ADDR_W(ADDR_W)) u_pins (
    .phase      (phase),
    .cfg_q      (cfg_q),
    .wr_q       (wr_q),
    .be_q       (be_q),
    .addr_q     (addr_q),
    .addr_pin_o (addr_pin_o),
    .rd_n_o     (rd_n_o),
    .wr_pin_o   (wr_pin_o),
    .hb_pin_o   (hb_pin_o),
    .done_o     (done_o),
    .ad_o       (ad_o)
  );

endmodule

// File: rtl/bsg_checker.sv
module bsg_checker
  import bsg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input phase_t            phase,
  input logic              start,
  input cfg_t              cfg_q,
  input logic              addr_pin_o,
  input logic              rd_n_o,
  input logic              wr_pin_o,
  input logic              hb_pin_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] ad_o
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R1

  AST_ADDR_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rd_n_o && wr_pin_o && !done_o)); // R1

  AST_LATCH_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.addr_style && addr_pin_o) |=> !addr_pin_o); // R2

  AST_VALID_HIGH_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cfg_q.addr_style) |-> addr_pin_o); // R3

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> wr_pin_o); // R4

  AST_NO_STROBE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rd_n_o && wr_pin_o && hb_pin_o)); // R5

  AST_AD_ZERO_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ad_o == '0)); // R7

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_ADDR) || (phase == PH_STRB)) |-> !start); // R8

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cfg_q)); // R9

endmodule

bind bus_strobe_gen bsg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase      (phase),
  .start      (start),
  .cfg_q      (cfg_q),
  .addr_pin_o (addr_pin_o),
  .rd_n_o     (rd_n_o),
  .wr_pin_o   (wr_pin_o),
  .hb_pin_o   (hb_pin_o),
  .done_o     (done_o),
  .ad_o       (ad_o)
);

// File: tb/bus_strobe_gen_bench.sv
module bus_strobe_gen_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 16;
  localparam int STROBE_CLKS = 2;
  localparam int CYC_LEN     = STROBE_CLKS + 2;
  localparam int RAND_CYCLES = 4000;
  localparam int WATCHDOG    = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_addr_style = 1'b1;
  logic              cfg_wr_style = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_be = '0;
  logic              addr_pin_o, rd_n_o, wr_pin_o, hb_pin_o, done_o;
  logic [ADDR_W-1:0] ad_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference model state: position within cycle, -1 when idle.
  int              m_pos = -1;
  bit              m_as = 1'b1, m_ws = 1'b1, m_wr = 1'b0;
  bit [1:0]        m_be = '0;
  bit [ADDR_W-1:0] m_addr = '0;
  int              starts_seen = 0;
  int              ignored_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_strobe_gen #(.ADDR_W(ADDR_W), .STROBE_CLKS(STROBE_CLKS)) u_bus_strobe_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_addr_style (cfg_addr_style),
    .cfg_wr_style   (cfg_wr_style),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_be         (req_be),
    .addr_pin_o     (addr_pin_o),
    .rd_n_o         (rd_n_o),
    .wr_pin_o       (wr_pin_o),
    .hb_pin_o       (hb_pin_o),
    .done_o         (done_o),
    .ad_o           (ad_o)
  );

  task automatic cmp(input string tag, input string sig, input logic [ADDR_W-1:0] act,
                     input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", tag, sig, $time, act, exp);
    end
  endtask

  // Compare at the falling edge, then advance the model with the inputs
  // the design will sample at the next rising edge.
  always @(negedge clk) begin
    bit addr_clk, strb_clk, recv_clk, e_as, e_rd, e_wr, e_hb;
    addr_clk = (m_pos == 0);
    strb_clk = (m_pos >= 1) && (m_pos <= STROBE_CLKS);
    recv_clk = (m_pos == CYC_LEN - 1);
    if (m_as) e_as = addr_clk;                     // R2 latch pulse
    else      e_as = !(addr_clk || strb_clk);      // R3 address valid
    e_rd = !(strb_clk && !m_wr);                   // R4
    if (m_ws) begin
      e_wr = !(strb_clk && m_wr);                  // R5 single strobe
      e_hb = !((addr_clk || strb_clk) && m_be[1]); // R6 high-byte enable
    end else begin
      e_wr = !(strb_clk && m_wr && m_be[0]);       // R5 low lane
      e_hb = !(strb_clk && m_wr && m_be[1]);       // R6 high lane
    end
    if (!rst_n) begin
      cmp("R10", "addr_pin", ADDR_W'(addr_pin_o), ADDR_W'(1'b1 ? 1'b0 : 1'b1));
      cmp("R10", "rd_n", ADDR_W'(rd_n_o), ADDR_W'(1));
      cmp("R10", "wr_pin", ADDR_W'(wr_pin_o), ADDR_W'(1));
      cmp("R10", "hb_pin", ADDR_W'(hb_pin_o), ADDR_W'(1));
      cmp("R10", "done", ADDR_W'(done_o), ADDR_W'(0));
      cmp("R10", "ad", ad_o, '0);
      m_pos = -1; m_as = 1'b1; m_ws = 1'b1; m_wr = 1'b0; m_be = '0; m_addr = '0;
    end else if (!finished) begin
      cmp(m_as ? "R2 R8 R9" : "R3 R8 R9", "addr_pin", ADDR_W'(addr_pin_o), ADDR_W'(e_as));
      cmp("R4 R8 R9", "rd_n", ADDR_W'(rd_n_o), ADDR_W'(e_rd));
      cmp("R5 R8 R9", "wr_pin", ADDR_W'(wr_pin_o), ADDR_W'(e_wr));
      cmp("R6 R8 R9", "hb_pin", ADDR_W'(hb_pin_o), ADDR_W'(e_hb));
      cmp("R1 R8", "done", ADDR_W'(done_o), ADDR_W'(recv_clk));
      cmp("R7 R9", "ad", ad_o, addr_clk ? m_addr : '0);
      if ((m_pos == -1 || recv_clk) && req_valid) begin
        m_pos = 0; m_as = cfg_addr_style; m_ws = cfg_wr_style;
        m_wr = req_write; m_be = req_be; m_addr = req_addr;
        starts_seen++;
      end else if (m_pos >= 0 && !recv_clk) begin
        if (req_valid) ignored_seen++;
        m_pos++;
      end else begin
        m_pos = -1;
      end
    end
  end

  task automatic step(input bit v, input bit w, input bit [1:0] be,
                      input bit [ADDR_W-1:0] a, input bit as, input bit ws);
    @(posedge clk);
    #1;
    req_valid = v; req_write = w; req_be = be; req_addr = a;
    cfg_addr_style = as; cfg_wr_style = ws;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step(0, 0, 2'b00, '0, 1, 1);          // R10 idle after reset
    // Directed: each personality, word read and byte writes.
    for (int m = 0; m < 4; m++) begin
      step(1, 0, 2'b11, ADDR_W'(16'h1230 + m), m[1], m[0]);
      step(0, 0, 2'b00, '0, m[1], m[0]);
      repeat (4) step(0, 0, 2'b00, '0, m[1], m[0]);
      for (int b = 1; b < 4; b++) begin
        step(1, 1, 2'(b), ADDR_W'(16'h4000 + b), m[1], m[0]);
        step(0, 1, 2'(b), '0, ~m[1], ~m[0]);          // R9 change mid-cycle
        repeat (4) step(0, 0, 2'b00, '0, m[1], m[0]);
      end
    end
    // Back-to-back with held request (R8).
    repeat (12) step(1, 1, 2'b10, 16'hBEEF, 0, 0);
    // Random traffic.
    for (int i = 0; i < RAND_CYCLES; i++) begin
      bit [3:0] r;
      r = 4'($urandom());
      step(r[0] | r[1], r[2], 2'($urandom()), ADDR_W'($urandom()),
           (r == 4'd0) ? ~cfg_addr_style : cfg_addr_style,
           (r == 4'd15) ? ~cfg_wr_style : cfg_wr_style);
    end
    repeat (6) step(0, 0, 2'b00, '0, 1, 1);
    @(negedge clk);
    #1;
    finished = 1'b1;
    checks++;                                         // R8 ignored requests occurred
    if (ignored_seen == 0 || starts_seen < 20) begin
      errors++;
      $display("FAIL R8 traffic coverage: actual starts %0d ignored %0d expected >=20 and >0",
               starts_seen, ignored_seen);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    finished = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule